// File: doc/BRIEF.md
# Deferrable Warm-Reset Sequencer

This block gathers a vector of system reset requests, sorts each one as fatal or non-fatal, and drives a warm system reset pulse. A non-fatal source whose interrupt enable is set does not reset the system straight away. It raises a pending flag and an interrupt, and a fixed window of slow-clock cycles opens. During that window software may shut down cleanly and let the reset happen. It may instead cancel the reset by first removing the request at its origin and then writing 1 to the pending flag.

The block keeps two status words. The last-reset word is replaced on every warm reset. The sticky word collects every cause seen since the last cold reset. Both carry one bit per source plus two summary bits, one for "a non-fatal source took part" and one for "a fatal source took part". Only the cold reset input clears either word. The whole block runs on the slow clock. The software side is modelled as one-cycle mask strobes.

Top module: `warm_rst_ctrl`

## Requirements
- R1: After cold reset (rst_ni low, released through a two-stage synchroniser) sys_rst_o, irq_o, ien_o, flags_o, last_o and sticky_o are all zero.
- R2: A request from a fatal source, or from a source whose delay is not enabled, makes sys_rst_o high after the clock edge that samples it.
- R3: A request from a delay-enabled source sets its bit in flags_o and drives irq_o high after the sampling edge. If any flag is still set, sys_rst_o rises exactly HOLD_CYC edges after that edge (258 by default).
- R4: A write-1 in flag_clr_i clears a flag only if the source's request is low in that cycle. When every flag is cleared, the window is abandoned and no reset follows.
- R5: sys_rst_o stays high for exactly PULSE_CYC cycles (4 by default). New requests and flag clears are ignored while it is high, and all flags are cleared when it starts, so irq_o is low during the pulse.
- R6: On each warm reset, last_o is replaced by: bits [N-1:0] = the requesting sources together with the pending flags; bit N = some non-fatal source is included; bit N+1 = some fatal source is included.
- R7: sticky_o ORs in the same word on every warm reset and clears bits written with 1 in sticky_clr_i. If the same bit is cleared and recorded in one cycle, recording wins.
- R8: ien_set_i ORs bits into ien_o and ien_clr_i removes bits. When both act in one cycle, the set applies after the clear. Only delayable source positions (by default bits 0 to 5; bits 6 and 7 are fatal) can ever be set.
- R9: The warm reset does not clear last_o or sticky_o. Only rst_ni clears them.
- R10: A fatal or non-enabled request that arrives during an open window triggers the reset at once. The pending source is recorded together with it.
- R11: Several requests sampled in the same cycle are all recorded together in last_o and sticky_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Slow clock |
| rst_ni | input | 1 | Cold reset, asynchronous, active low |
| req_i | input | NSRC | Reset request per source, level |
| ien_set_i | input | NSRC | Strobe mask: OR into interrupt enables |
| ien_clr_i | input | NSRC | Strobe mask: remove interrupt enables |
| flag_clr_i | input | NSRC | Strobe mask: write-1-to-clear pending flags |
| sticky_clr_i | input | NSRC+2 | Strobe mask: write-1-to-clear sticky word |
| sys_rst_o | output | 1 | Warm system reset, active high |
| irq_o | output | 1 | Pending-reset interrupt |
| ien_o | output | NSRC | Interrupt enables |
| flags_o | output | NSRC | Pending reset flags |
| last_o | output | NSRC+2 | Cause of the most recent warm reset |
| sticky_o | output | NSRC+2 | Accumulated causes since cold reset |

## Verification
Every result is registered. An undelayed reset, a new flag, a new enable or a cleared sticky bit is visible after the first edge that samples the stimulus. A deferred reset appears after edge HOLD_CYC counted from the sampling edge, and the pulse ends after PULSE_CYC edges. The bench updates a behavioural model at each rising edge from the inputs it holds steady across that edge. It compares every output at the following falling edge. Directed checks count falling edges from the stimulus, so the deferral and the pulse length are measured exactly.

// File: rtl/wrc_pkg.sv
package wrc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HOLD = 2'd1,
    ST_RST  = 2'd2
  } wrc_state_e;

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/wrc_rst_sync.sv
module wrc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) sync_q <= '0;
    else          sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/wrc_irq_regs.sv
module wrc_irq_regs #(
  parameter int unsigned     NSRC      = 8,
  parameter logic [NSRC-1:0] DLY_MASK  = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] req_i,
  input  logic [NSRC-1:0] ien_set_i,
  input  logic [NSRC-1:0] ien_clr_i,
  input  logic [NSRC-1:0] flag_clr_i,
  input  logic            freeze_i,
  output logic [NSRC-1:0] ien_o,
  output logic [NSRC-1:0] den_o,
  output logic [NSRC-1:0] flags_o,
  output logic [NSRC-1:0] flags_nxt_o
);
  logic [NSRC-1:0] ien_q, ien_d;
  logic [NSRC-1:0] flags_q, flags_d;
  logic            ien_en;

  always_comb begin
    ien_en = |ien_set_i | |ien_clr_i;
    ien_d  = ((ien_q & ~ien_clr_i) | ien_set_i) & DLY_MASK;
  end

  always_comb begin
    den_o       = ien_q & DLY_MASK;
    flags_nxt_o = (flags_q & ~(flag_clr_i & ~req_i)) | (req_i & den_o);
    flags_d     = freeze_i ? '0 : flags_nxt_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ien_q <= '0;
    else if (ien_en) ien_q <= ien_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= flags_d;
  end

  assign ien_o   = ien_q;
  assign flags_o = flags_q;

  // R4: a flag whose request is still high survives unless the reset starts
  assert_flag_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!freeze_i && ((flags_q & req_i) != '0)) |=> (flags_q != '0));

  // R8: only delayable positions can become enabled
  assert_ien_legal_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ien_en |=> ((ien_q & ~DLY_MASK) == '0));
endmodule

// File: rtl/wrc_sequencer.sv
module wrc_sequencer
  import wrc_pkg::*;
#(
  parameter int unsigned     NSRC       = 8,
  parameter logic [NSRC-1:0] FATAL_MASK = '0,
  parameter int unsigned     HOLD_CYC   = 258,
  parameter int unsigned     PULSE_CYC  = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] req_i,
  input  logic [NSRC-1:0] den_i,
  input  logic [NSRC-1:0] flags_nxt_i,
  output logic            go_o,
  output logic [NSRC-1:0] rec_o,
  output logic            in_rst_o
);
  localparam int unsigned CW = cnt_width(HOLD_CYC);
  localparam int unsigned PW = cnt_width(PULSE_CYC);
  localparam logic [CW-1:0] CNT_LAST = CW'(HOLD_CYC - 1);
  localparam logic [PW-1:0] PUL_LAST = PW'(PULSE_CYC - 1);

  wrc_state_e      state_q, state_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic [PW-1:0]   pcnt_q, pcnt_d;
  logic [NSRC-1:0] imm;
  logic            expire;
  logic            go;

  always_comb begin
    imm    = req_i & ~den_i;
    expire = (state_q == ST_HOLD) && (cnt_q == CNT_LAST) && (flags_nxt_i != '0);
    go     = (state_q != ST_RST) && ((imm != '0) || expire);
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    pcnt_d  = pcnt_q;
    if (go) begin
      state_d = ST_RST;
      pcnt_d  = '0;
      cnt_d   = '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (flags_nxt_i != '0) begin
            state_d = ST_HOLD;
            cnt_d   = '0;
          end
        end
        ST_HOLD: begin
          if (flags_nxt_i != '0) begin
            cnt_d = cnt_q + 1'b1;
          end else begin
            state_d = ST_IDLE;
            cnt_d   = '0;
          end
        end
        ST_RST: begin
          if (pcnt_q == PUL_LAST) begin
            state_d = ST_IDLE;
            pcnt_d  = '0;
          end else begin
            pcnt_d = pcnt_q + 1'b1;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      pcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      pcnt_q  <= pcnt_d;
    end
  end

  assign go_o     = go;
  assign rec_o    = req_i | flags_nxt_i;
  assign in_rst_o = (state_q == ST_RST);

  // R2: a fatal request outside the pulse starts the reset on the next edge
  assert_fatal_now_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q != ST_RST) && ((req_i & FATAL_MASK) != '0)) |=> (state_q == ST_RST));

  // R3: the window counter stays inside the window
  assert_window_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HOLD) |-> (cnt_q <= CNT_LAST));

  // R5: pulse counter stays inside the pulse
  assert_pulse_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RST) |-> (pcnt_q <= PUL_LAST));
endmodule

// File: rtl/wrc_status.sv
module wrc_status #(
  parameter int unsigned     NSRC       = 8,
  parameter logic [NSRC-1:0] FATAL_MASK = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            go_i,
  input  logic [NSRC-1:0] rec_i,
  input  logic [NSRC+1:0] sticky_clr_i,
  output logic [NSRC+1:0] last_o,
  output logic [NSRC+1:0] sticky_o
);
  localparam int unsigned W = NSRC + 2;

  logic [W-1:0] word;
  logic [W-1:0] last_q, last_d;
  logic [W-1:0] sticky_q, sticky_d;
  logic         sticky_en;

  always_comb begin
    word      = {|(rec_i & FATAL_MASK), |(rec_i & ~FATAL_MASK), rec_i};
    last_d    = word;
    sticky_en = go_i | (sticky_clr_i != '0);
    sticky_d  = (sticky_q & ~sticky_clr_i) | (go_i ? word : '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   last_q <= '0;
    else if (go_i) last_q <= last_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        sticky_q <= '0;
    else if (sticky_en) sticky_q <= sticky_d;
  end

  assign last_o   = last_q;
  assign sticky_o = sticky_q;

  // R7: a sticky bit drops only when written with 1
  assert_sticky_keep_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((sticky_q & $past(sticky_q & ~sticky_clr_i)) == $past(sticky_q & ~sticky_clr_i)));

  // R9: the last-reset word changes only when a reset starts
  assert_last_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !go_i |=> $stable(last_q));
endmodule

// File: rtl/warm_rst_ctrl.sv
module warm_rst_ctrl #(
  parameter int unsigned     NSRC       = 8,
  parameter logic [NSRC-1:0] FATAL_MASK = 8'hC0,
  parameter logic [NSRC-1:0] DLY_MASK   = 8'h3F,
  parameter int unsigned     HOLD_CYC   = 258,
  parameter int unsigned     PULSE_CYC  = 4,
  parameter int unsigned     SYNC_STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] req_i,
  input  logic [NSRC-1:0] ien_set_i,
  input  logic [NSRC-1:0] ien_clr_i,
  input  logic [NSRC-1:0] flag_clr_i,
  input  logic [NSRC+1:0] sticky_clr_i,
  output logic            sys_rst_o,
  output logic            irq_o,
  output logic [NSRC-1:0] ien_o,
  output logic [NSRC-1:0] flags_o,
  output logic [NSRC+1:0] last_o,
  output logic [NSRC+1:0] sticky_o
);
  localparam logic [NSRC-1:0] DLY_EFF = DLY_MASK & ~FATAL_MASK;

  logic            rst_n_s;
  logic [NSRC-1:0] den;
  logic [NSRC-1:0] flags_nxt;
  logic [NSRC-1:0] rec;
  logic            go;
  logic            in_rst;
  logic            freeze;

  assign freeze = in_rst | go;

  wrc_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .arst_ni (rst_ni),
    .rst_no  (rst_n_s)
  );

  wrc_irq_regs #(.NSRC(NSRC), .DLY_MASK(DLY_EFF)) u_irq (
    .clk_i       (clk_i),
    .rst_ni      (rst_n_s),
    .req_i       (req_i),
    .ien_set_i   (ien_set_i),
    .ien_clr_i   (ien_clr_i),
    .flag_clr_i  (flag_clr_i),
    .freeze_i    (freeze),
    .ien_o       (ien_o),
    .den_o       (den),
    .flags_o     (flags_o),
    .flags_nxt_o (flags_nxt)
  );

  wrc_sequencer #(
    .NSRC(NSRC), .FATAL_MASK(FATAL_MASK), .HOLD_CYC(HOLD_CYC), .PULSE_CYC(PULSE_CYC)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_n_s),
    .req_i       (req_i),
    .den_i       (den),
    .flags_nxt_i (flags_nxt),
    .go_o        (go),
    .rec_o       (rec),
    .in_rst_o    (in_rst)
  );

  wrc_status #(.NSRC(NSRC), .FATAL_MASK(FATAL_MASK)) u_stat (
    .clk_i        (clk_i),
    .rst_ni       (rst_n_s),
    .go_i         (go),
    .rec_i        (rec),
    .sticky_clr_i (sticky_clr_i),
    .last_o       (last_o),
    .sticky_o     (sticky_o)
  );

  assign sys_rst_o = in_rst;
  assign irq_o     = |flags_o;

  // R5: no pending interrupt while the warm reset pulse is driven
  assert_irq_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    sys_rst_o |-> !irq_o);

  // R6: a rising reset pulse always comes with a recorded cause
  assert_cause_logged_R6: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    $rose(sys_rst_o) |-> (last_o[NSRC+1:NSRC] != 2'b00));
endmodule

// File: tb/tb_warm_rst_ctrl.sv
module tb_warm_rst_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam int HOLD = 258;
  localparam int PULSE = 4;
  localparam logic [N-1:0] FAT = 8'hC0;
  localparam logic [N-1:0] DLY = 8'h3F;

  logic clk = 1'b0;
  logic rst_n;
  logic [N-1:0] req, ien_set, ien_clr, fclr;
  logic [N+1:0] sclr;
  logic sys_rst, irq;
  logic [N-1:0] ien, flags;
  logic [N+1:0] last, sticky;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  warm_rst_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .ien_set_i(ien_set),
    .ien_clr_i(ien_clr), .flag_clr_i(fclr), .sticky_clr_i(sclr),
    .sys_rst_o(sys_rst), .irq_o(irq), .ien_o(ien), .flags_o(flags),
    .last_o(last), .sticky_o(sticky)
  );

  // behavioural reference
  logic [N-1:0] m_ien, m_flags;
  logic [N+1:0] m_last, m_sticky;
  int m_state, m_cnt, m_p, m_sync;

  always @(posedge clk) begin
    logic [N-1:0] den, imm, fn, rec;
    logic [N+1:0] w;
    bit go;
    if (!rst_n) begin
      m_ien = '0; m_flags = '0; m_last = '0; m_sticky = '0;
      m_state = 0; m_cnt = 0; m_p = 0; m_sync = 0;
    end else if (m_sync < 2) begin
      m_sync++;
    end else begin
      den = m_ien & DLY;
      imm = req & ~den;
      fn  = (m_flags & ~(fclr & ~req)) | (req & den);
      rec = req | fn;
      w   = {|(rec & FAT), |(rec & ~FAT), rec};
      go  = (m_state != 2) && ((imm != 0) || (m_state == 1 && m_cnt == HOLD-1 && fn != 0));
      m_sticky = (m_sticky & ~sclr) | (go ? w : '0);
      if (go) begin
        m_last = w; m_state = 2; m_p = 0; m_flags = '0;
      end else if (m_state == 2) begin
        m_flags = '0;
        if (m_p == PULSE-1) m_state = 0; else m_p++;
      end else if (fn != 0) begin
        m_cnt = (m_state == 0) ? 0 : m_cnt + 1;
        m_state = 1; m_flags = fn;
      end else begin
        m_state = 0; m_flags = '0;
      end
      m_ien = ((m_ien & ~ien_clr) | ien_set) & DLY;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n && m_sync >= 2) begin
      check("R2 model sys_rst", 32'(sys_rst), 32'(m_state == 2));
      check("R3 model irq", 32'(irq), 32'(m_flags != 0));
      check("R4 model flags", 32'(flags), 32'(m_flags));
      check("R6 model last", 32'(last), 32'(m_last));
      check("R7 model sticky", 32'(sticky), 32'(m_sticky));
      check("R8 model ien", 32'(ien), 32'(m_ien));
    end
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    fails++;
    $display("FAIL watchdog expired act=%0d exp=done", cycles);
    finish_run();
  end

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ien_set = '0; ien_clr = '0; fclr = '0; sclr = '0;
    end
  endtask

  initial begin
    int m;
    bit seen;
    rst_n = 1'b0; req = '0; ien_set = '0; ien_clr = '0; fclr = '0; sclr = '0;
    tick(3);
    rst_n = 1'b1;
    tick(4);
    // R1 reset state
    check("R1 sys_rst", 32'(sys_rst), 0);
    check("R1 irq", 32'(irq), 0);
    check("R1 ien", 32'(ien), 0);
    check("R1 last", 32'(last), 0);
    check("R1 sticky", 32'(sticky), 0);

    // R2 fatal source, R5 pulse length
    req = 8'h80; tick();
    req = '0;
    check("R2 fatal immediate", 32'(sys_rst), 1);
    check("R6 fatal word", 32'(last), 32'h280);
    tick(3);
    check("R5 pulse still high", 32'(sys_rst), 1);
    tick();
    check("R5 pulse ended", 32'(sys_rst), 0);

    // R2 non-enabled delayable source
    req = 8'h04; tick();
    req = '0;
    check("R2 not enabled immediate", 32'(sys_rst), 1);
    check("R6 warm word", 32'(last), 32'h104);
    check("R9 sticky survives", 32'(sticky), 32'h384);
    tick(4);

    // R8 enables
    ien_set = 8'h87; tick();
    check("R8 fatal bit not settable", 32'(ien), 32'h07);
    ien_clr = 8'h02; ien_set = 8'h08; tick();
    check("R8 set and clear", 32'(ien), 32'h0D);
    ien_clr = 8'h08; tick();
    check("R8 clear", 32'(ien), 32'h05);

    // R3 deferred reset
    req = 8'h01; tick();
    req = '0;
    check("R3 irq raised", 32'(irq), 1);
    check("R3 flag set", 32'(flags), 32'h01);
    check("R3 no reset yet", 32'(sys_rst), 0);
    m = 0;
    while (!sys_rst && m < 400) begin tick(); m++; end
    check("R3 window length", 32'(m), 32'(HOLD));
    check("R6 deferred word", 32'(last), 32'h101);
    tick(4);

    // R4 cancel
    req = 8'h04; tick();
    fclr = 8'h04; tick();
    check("R4 clear ignored while requested", 32'(flags), 32'h04);
    req = '0; fclr = 8'h04; tick();
    check("R4 flag cleared", 32'(flags), 0);
    check("R4 irq dropped", 32'(irq), 0);
    seen = 0;
    for (int i = 0; i < 300; i++) begin tick(); if (sys_rst) seen = 1; end
    check("R4 reset cancelled", 32'(seen), 0);

    // R10 preemption, R5 ignore during pulse
    req = 8'h01; tick();
    req = '0; tick(10);
    req = 8'h40; tick();
    check("R10 preempt immediate", 32'(sys_rst), 1);
    check("R10 both recorded", 32'(last), 32'h341);
    req = 8'h80; tick();
    req = '0; tick(3);
    check("R5 pulse ended after preempt", 32'(sys_rst), 0);
    check("R5 request in pulse ignored", 32'(last), 32'h341);

    // R11 simultaneous sources
    req = 8'h18; tick();
    req = '0;
    check("R11 both sources", 32'(last), 32'h118);
    tick(4);
    check("R9 sticky union", 32'(sticky), 32'h3DD);

    // R7 sticky clear and set-wins
    sclr = 10'h0C1; tick();
    check("R7 w1c", 32'(sticky), 32'h31C);
    req = 8'h20; sclr = 10'h120; tick();
    req = '0;
    check("R7 record wins", 32'(sticky), 32'h33C);
    tick(6);
    finish_run();
  end
endmodule